// File: doc/BRIEF.md
# Saturating Signed-Byte Vector Adder

This execution unit receives one 32-bit instruction word together with two 128-bit operands. It checks the word against a single fixed encoding. When the word matches, the unit splits each operand into sixteen signed 8-bit lanes and adds the lanes pair by pair. Any lane sum that falls outside the signed byte range is clamped to the nearest limit. One cycle later the unit presents the 128-bit result, a write strobe and the destination register index taken from the instruction. The register file that receives the result sits outside the unit.

The unit also owns a 32-bit vector status register. Its bit 0 is a sticky saturation flag. A matching instruction sets this flag when at least one lane clamped, in either direction. Adds never clear the flag. It changes back only when software writes the register through a dedicated write port. A software write takes effect on the same edge as an add and wins over it.

The control path is a two-state machine:
- `ST_IDLE`: no result is being presented.
- `ST_EMIT`: the result, strobe and index from the previous cycle are valid.

The transitions are:
- `accept`: an idle unit receives a matching instruction and moves to `ST_EMIT`.
- `stream`: a matching instruction arrives while the unit is in `ST_EMIT`, and the unit stays in `ST_EMIT`.
- `drain`: a cycle passes with no matching instruction, and the unit returns to `ST_IDLE`.

Top module: `simd_sat_add_unit`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is high, `instr_word[31:26]` equals 4 and `instr_word[10:0]` equals 768. The three 5-bit register fields may hold any value.
- R2: One clock after an accepted instruction, `res_we` is high and `res_dst` equals `instr_word[25:21]` of that instruction.
- R3: Lane i occupies bits `[127-8i -: 8]`, so lane 0 is the top byte and lane 15 the bottom byte. Each lane of `res_data` is the two's-complement sum of the matching lanes of A and B when that sum lies in -128..127. The lanes are independent of one another.
- R4: A lane whose true sum exceeds +127 yields 0x7F. For example, 0x7F plus 0x01 gives 0x7F.
- R5: A lane whose true sum is below -128 yields 0x80. For example, 0x80 plus 0xFF gives 0x80.
- R6: `stat_q[0]` becomes 1 on the same edge that produces the result of an accepted instruction in which any lane clamped, in either direction.
- R7: An accepted instruction never clears `stat_q[0]`. A result in which no lane clamps leaves `stat_q` unchanged.
- R8: When `stat_wr_en` is high, `stat_q` takes `stat_wr_data` at the next edge. This holds even when an accepted instruction that saturates arrives in the same cycle.
- R9: A word that does not match, or a matching word while `instr_valid` is low, produces `res_we` low on the next cycle and leaves `stat_q` unchanged.
- R10: While reset is asserted, `res_we` is 0 and `stat_q` is 0.
- R11: Matching instructions on consecutive cycles produce a result on each of the following consecutive cycles.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| opnd_a | input | 128 | First vector operand |
| opnd_b | input | 128 | Second vector operand |
| stat_wr_en | input | 1 | Software write strobe for the status register |
| stat_wr_data | input | 32 | Software write data for the status register |
| res_data | output | 128 | Clamped lane-wise sum |
| res_we | output | 1 | Result write strobe |
| res_dst | output | 5 | Destination register index |
| stat_q | output | 32 | Status register; bit 0 is the sticky saturation flag |

## Verification
The bench targets the two asymmetric limits, +127 plus 1 and -128 plus -1, placed in the lanes at each end of the vector. A design that wraps instead of clamping would show 0x80 or 0x7F in the wrong lane. A design with swapped lane order would put the clamped value at the opposite end. The bench also checks that a later non-saturating add leaves the sticky flag set, since a design that copies the per-instruction flag would clear it. It drives a software write in the same cycle as a saturating add, where a design with the wrong priority would leave bit 0 set. Words that are off by one in the extended opcode, or that carry a different primary opcode, must produce no write strobe. A loose decoder would produce one.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
    localparam int INSTR_W     = 32;
    localparam int REG_IDX_W   = 5;
    localparam int PRIM_W      = 6;
    localparam int XOP_W       = 11;
    localparam logic [PRIM_W-1:0] PRIM_OP = 6'd4;
    localparam logic [XOP_W-1:0]  EXT_OP  = 11'd768;
    localparam int SAT_FLAG_BIT = 0;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } unit_state_t;
endpackage

// File: rtl/vx_decode.sv
module vx_decode
    import simd_sat_pkg::*;
(
    input  logic                 valid,
    input  logic [INSTR_W-1:0]   word,
    output logic                 hit,
    output logic [REG_IDX_W-1:0] dst
);
    localparam int PRIM_LSB = INSTR_W - PRIM_W;
    localparam int DST_LSB  = PRIM_LSB - REG_IDX_W;

    logic unused_src_fields;

    always_comb begin
        hit = valid
            && (word[INSTR_W-1:PRIM_LSB] == PRIM_OP)
            && (word[XOP_W-1:0] == EXT_OP);
        dst = word[DST_LSB +: REG_IDX_W];
    end

    assign unused_src_fields = ^word[DST_LSB-1:XOP_W];
endmodule

// File: rtl/sat_lane_add.sv
module sat_lane_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         clamped
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;

    always_comb begin
        raw     = a + b;
        clamped = (a[W-1] == b[W-1]) && (raw[W-1] != a[W-1]);
        if (clamped)
            y = a[W-1] ? NEG_LIM : POS_LIM;
        else
            y = raw;
    end
endmodule

// File: rtl/vstat_reg.sv
module vstat_reg #(
    parameter int STAT_W   = 32,
    parameter int FLAG_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [STAT_W-1:0] sw_data,
    input  logic              sat_set,
    output logic [STAT_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (sw_we)
            q <= sw_data;
        else if (sat_set)
            q[FLAG_BIT] <= 1'b1;
    end
endmodule

// File: rtl/simd_sat_add_unit.sv
module simd_sat_add_unit
    import simd_sat_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8,
    parameter int STAT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr_word,
    input  logic [VEC_W-1:0]     opnd_a,
    input  logic [VEC_W-1:0]     opnd_b,
    input  logic                 stat_wr_en,
    input  logic [STAT_W-1:0]    stat_wr_data,
    output logic [VEC_W-1:0]     res_data,
    output logic                 res_we,
    output logic [REG_IDX_W-1:0] res_dst,
    output logic [STAT_W-1:0]    stat_q
);
    localparam int N_LANES = VEC_W / LANE_W;

    unit_state_t          state_q, state_d;
    logic                 hit;
    logic [REG_IDX_W-1:0] dec_dst;
    logic [VEC_W-1:0]     sum_vec;
    logic [N_LANES-1:0]   lane_clamp;
    logic [VEC_W-1:0]     res_q;
    logic [REG_IDX_W-1:0] dst_q;

    vx_decode u_dec (
        .valid (instr_valid),
        .word  (instr_word),
        .hit   (hit),
        .dst   (dec_dst)
    );

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        localparam int HI = VEC_W - 1 - i * LANE_W;
        sat_lane_add #(.W(LANE_W)) u_lane (
            .a       (opnd_a[HI -: LANE_W]),
            .b       (opnd_b[HI -: LANE_W]),
            .y       (sum_vec[HI -: LANE_W]),
            .clamped (lane_clamp[i])
        );
    end

    vstat_reg #(.STAT_W(STAT_W), .FLAG_BIT(SAT_FLAG_BIT)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (stat_wr_en),
        .sw_data (stat_wr_data),
        .sat_set (hit && (|lane_clamp)),
        .q       (stat_q)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit)  state_d = ST_EMIT;
            ST_EMIT: if (!hit) state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            dst_q <= '0;
        end else if (hit) begin
            res_q <= sum_vec;
            dst_q <= dec_dst;
        end
    end

    always_comb begin
        res_data = res_q;
        res_dst  = dst_q;
        unique case (state_q)
            ST_IDLE: res_we = 1'b0;
            ST_EMIT: res_we = 1'b1;
            default: res_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/simd_sat_add_chk.sv
module simd_sat_add_chk #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [31:0]       instr_word,
    input logic [VEC_W-1:0]  opnd_a,
    input logic [VEC_W-1:0]  opnd_b,
    input logic              stat_wr_en,
    input logic [STAT_W-1:0] stat_wr_data,
    input logic [VEC_W-1:0]  res_data,
    input logic              res_we,
    input logic [4:0]        res_dst,
    input logic [STAT_W-1:0] stat_q
);
    localparam int N_LANES = VEC_W / LANE_W;

    logic past_ok;
    logic unused_src_bits;

    assign unused_src_bits = ^instr_word[20:11];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_dst_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && res_we |-> res_dst == $past(instr_word[25:21]));

    assert_we_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && res_we |-> $past(instr_valid) && ($past(instr_word[31:26]) == 6'd4)
                              && ($past(instr_word[10:0]) == 11'd768));

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $fell(stat_q[0]) |-> $past(stat_wr_en));

    assert_sw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(stat_wr_en) |-> stat_q == $past(stat_wr_data));

    assert_quiet_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(stat_wr_en) && !res_we |-> $stable(stat_q));

    for (genvar i = 0; i < N_LANES; i++) begin : g_sign
        localparam int HI = VEC_W - 1 - i * LANE_W;
        assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && res_we && ($past(opnd_a[HI]) == $past(opnd_b[HI]))
            |-> res_data[HI] == $past(opnd_a[HI]));
    end

    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (res_we == 1'b0 && stat_q == '0);
        end
    end
endmodule

bind simd_sat_add_unit simd_sat_add_chk #(.VEC_W(VEC_W), .LANE_W(LANE_W), .STAT_W(STAT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr_word   (instr_word),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .stat_wr_en   (stat_wr_en),
    .stat_wr_data (stat_wr_data),
    .res_data     (res_data),
    .res_we       (res_we),
    .res_dst      (res_dst),
    .stat_q       (stat_q)
);

// File: tb/simd_sat_add_unit_tb.sv
module simd_sat_add_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [31:0]  instr_word = '0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         stat_wr_en = 1'b0;
    logic [31:0]  stat_wr_data = '0;
    logic [127:0] res_data;
    logic         res_we;
    logic [4:0]   res_dst;
    logic [31:0]  stat_q;

    int n_checks = 0;
    int n_fails  = 0;

    logic [127:0] exp_res;
    logic         exp_we = 1'b0;
    logic [4:0]   exp_dst;
    logic [31:0]  exp_stat = '0;

    always #5 clk = ~clk;

    simd_sat_add_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr_word   (instr_word),
        .opnd_a       (opnd_a),
        .opnd_b       (opnd_b),
        .stat_wr_en   (stat_wr_en),
        .stat_wr_data (stat_wr_data),
        .res_data     (res_data),
        .res_we       (res_we),
        .res_dst      (res_dst),
        .stat_q       (stat_q)
    );

    function automatic logic [31:0] enc(input logic [4:0] d, input logic [4:0] sa, input logic [4:0] sb);
        return {6'd4, d, sa, sb, 11'd768};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_add(input logic [127:0] a, input logic [127:0] b,
                             output logic [127:0] r, output logic any_sat);
        any_sat = 1'b0;
        r = '0;
        for (int i = 0; i < 16; i++) begin
            int s;
            s = int'($signed(a[127-8*i -: 8])) + int'($signed(b[127-8*i -: 8]));
            if (s > 127) begin s = 127; any_sat = 1'b1; end
            if (s < -128) begin s = -128; any_sat = 1'b1; end
            r[127-8*i -: 8] = 8'(s);
        end
    endtask

    task automatic apply(input logic v, input logic [31:0] w, input logic [127:0] a,
                         input logic [127:0] b, input logic swe, input logic [31:0] swd,
                         input string tag);
        logic [127:0] r;
        logic sat;
        logic match;
        instr_valid  = v;
        instr_word   = w;
        opnd_a       = a;
        opnd_b       = b;
        stat_wr_en   = swe;
        stat_wr_data = swd;
        match = v && (w[31:26] == 6'd4) && (w[10:0] == 11'd768);
        model_add(a, b, r, sat);
        exp_we = match;
        if (match) begin
            exp_res = r;
            exp_dst = w[25:21];
        end
        if (swe) exp_stat = swd;
        else if (match && sat) exp_stat = exp_stat | 32'h1;
        @(posedge clk);
        @(negedge clk);
        check({tag, " res_we"}, 128'(res_we), 128'(exp_we));
        check({tag, " stat_q"}, 128'(stat_q), 128'(exp_stat));
        if (exp_we) begin
            check({tag, " res_data"}, res_data, exp_res);
            check({tag, " res_dst"}, 128'(res_dst), 128'(exp_dst));
        end
    endtask

    task automatic idle(input string tag);
        apply(1'b0, 32'h0, '0, '0, 1'b0, 32'h0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset res_we", 128'(res_we), 128'(0));
        check("R10 reset stat_q", 128'(stat_q), 128'(0));
        rst_n = 1'b1;
        idle("R10 after reset");

        apply(1'b1, enc(5'd7, 5'd3, 5'd9),
              128'h01_02_03_04_FB_F6_10_20_7E_81_00_40_C0_11_22_33,
              128'h10_20_30_40_02_03_F0_E0_01_FF_00_3F_C0_22_11_01,
              1'b0, 0, "R1 R2 R3 plain add");
        idle("R2 drain");

        apply(1'b1, enc(5'd1, 5'd1, 5'd1), {8'h7F, 120'h0}, {8'h01, 120'h0},
              1'b0, 0, "R4 R6 lane0 +127+1");
        apply(1'b1, enc(5'd2, 5'd0, 5'd0), {16{8'h05}}, {16{8'h06}},
              1'b0, 0, "R7 sticky held");
        apply(1'b0, 0, '0, '0, 1'b1, 32'h0, "R8 sw clear");
        apply(1'b1, enc(5'd31, 5'd31, 5'd31), {120'h0, 8'h80}, {120'h0, 8'hFF},
              1'b0, 0, "R5 R6 lane15 -128-1");
        apply(1'b1, enc(5'd4, 5'd4, 5'd4), {16{8'h80}}, {16{8'h80}},
              1'b1, 32'hA5A5_A5A4, "R8 sw write beats sticky set");
        apply(1'b1, enc(5'd6, 5'd0, 5'd0), {16{8'h70}}, {16{8'h70}},
              1'b0, 0, "R6 all lanes positive clamp");
        apply(1'b0, 0, '0, '0, 1'b1, 32'h0, "R8 sw clear again");
        apply(1'b1, {6'd5, 15'h0, 11'd768}, {8'h7F, 120'h0}, {8'h7F, 120'h0},
              1'b0, 0, "R9 R1 wrong primary opcode");
        apply(1'b1, {6'd4, 15'h0, 11'd769}, {8'h7F, 120'h0}, {8'h7F, 120'h0},
              1'b0, 0, "R9 R1 wrong extended opcode");
        apply(1'b0, enc(5'd3, 5'd3, 5'd3), {8'h7F, 120'h0}, {8'h7F, 120'h0},
              1'b0, 0, "R9 valid low");
        apply(1'b1, enc(5'd10, 5'd0, 5'd0), {16{8'h01}}, {16{8'h02}},
              1'b0, 0, "R11 back to back first");
        apply(1'b1, enc(5'd11, 5'd0, 5'd0), {16{8'hF0}}, {16{8'h0F}},
              1'b0, 0, "R11 back to back second");
        idle("R11 drain");

        for (int k = 0; k < 400; k++) begin
            logic [31:0] w;
            logic [127:0] a;
            logic [127:0] b;
            if ($urandom_range(0, 3) != 0)
                w = {6'd4, 15'($urandom), 11'd768};
            else
                w = $urandom;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            apply($urandom_range(0, 4) != 0, w, a, b, $urandom_range(0, 7) == 0,
                  $urandom, "R3 R6 R7 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule